// File: doc/BRIEF.md
# Urgency-Ordered Iterative Cell Scheduler

This block schedules cells across a 4x4 input-queued switch that keeps one virtual output queue per input/output pair. It behaves like the scheduler of an output-queued switch. Each queued cell is given a departure deadline, called its urgency. The urgency counts how many cells would sit ahead of it in a FIFO at its output. Every phase start lowers each deadline by one, and the count stops at zero. The block then runs request/grant rounds. In each round, every free output asks for its most urgent reachable head cell, and every input accepts the most urgent of the requests it receives.

Outputs that lose the contention request their next best input in the following round. Rounds stop when a round adds no grant or after N rounds, whichever comes first. The block then presents the input-to-output matching with a one-cycle valid pulse and per-input transfer strobes, and removes the transferred head cells from its queue bookkeeping. Only the head cell of each queue carries an urgency value. When a head cell leaves and cells remain behind it, the new head takes as its urgency the number of cells for that output that wait at the other inputs.

Top module: `urgency_sched`

## Requirements
- R1: After synchronous active-high reset, busy_o, match_vld_o and match_hit_o are 0 and every queue is empty. A phase started in that state completes with no input matched.
- R2: A cell accepted into an empty queue for output j gets an urgency equal to the number of cells for output j held at the start of the cycle, plus the accepted arrivals to j in the same cycle from lower-numbered inputs. An arrival to a non-empty queue leaves the head urgency unchanged.
- R3: Each queue holds at most 16 cells. An arrival to a full queue is dropped, does not count toward other arrivals' urgency, and never leads to a transfer.
- R4: Each phase_start_i that is accepted lowers the head urgency of every non-empty queue by one. The urgency saturates at zero.
- R5: In each round, every unmatched output requests the unmatched input whose non-empty queue for it has the smallest head urgency, with the lowest input winning ties. An empty queue is never requested.
- R6: With TIE_RR=0, an input grants the requesting output with the smallest head urgency, with the lowest output winning ties. No two matched inputs ever share an output.
- R7: With TIE_RR=1, ties at an input go to the first tied output at or after a per-input pointer. The pointer moves to one past the output that the input transferred to in its last matched phase, wrapping to 0 after output N-1.
- R8: An accepted phase start raises busy_o on the next cycle. Rounds continue until one round adds no grant or N rounds have run. match_vld_o then pulses for exactly one cycle, as busy_o falls, at most N cycles after the start edge.
- R9: With match_vld_o, match_hit_o[i] marks matched inputs, match_dst_o[i] gives the output (0 when unmatched), and xfer_o equals match_hit_o. Each transferred queue loses one cell. If cells remain, the new head's urgency is the number of cells for that output held at the other inputs.
- R10: phase_start_i is ignored while busy_o is high. No second phase follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| arv_vld_i | input | N | Per-input cell arrival valid |
| arv_dst_i | input | N x log2(N) | Per-input arrival destination output |
| phase_start_i | input | 1 | Starts one scheduling phase (one time slot) |
| busy_o | output | 1 | Request/grant rounds in progress |
| match_vld_o | output | 1 | One-cycle pulse: matching complete |
| match_hit_o | output | N | Input i is matched |
| match_dst_o | output | N x log2(N) | Output matched to input i |
| xfer_o | output | N | Per-input cell transfer strobe |

## Verification
Two instances are driven with the same stimulus, one breaking ties by lowest output and one by rotating pointer. A single directed sequence gives one input equally urgent cells for two outputs, which separates the two tie-break schemes. Simultaneous arrivals to the same output check the ordering of urgency by input number. A seventeen-cell burst into one queue, drained over seventeen phases, exposes the depth limit and the dropped arrival. Random arrival bursts build contention patterns in which lost outputs must fall back across several rounds. Idle stretches with no transfers drive urgencies to zero and test the saturation. Starts issued while a phase is running test that they are ignored.

// File: rtl/urg_sched_pkg.sv
package urg_sched_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_st_e;
endpackage

// File: rtl/min_pick.sv
// Picks the valid entry with the smallest value; the scan starts at start_i
// and wraps, so the first entry in scan order wins a tie.
module min_pick #(
    parameter  int N  = 4,
    parameter  int W  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         vld_i,
    input  logic [N-1:0][W-1:0]  val_i,
    input  logic [IW-1:0]        start_i,
    output logic                 hit_o,
    output logic [IW-1:0]        idx_o
);
    logic [W-1:0] best;
    int           c;

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        best  = '0;
        c     = 0;
        for (int k = 0; k < N; k++) begin
            c = int'(start_i) + k;
            if (c >= N) c = c - N;
            if (vld_i[c] && (!hit_o || (val_i[c] < best))) begin
                hit_o = 1'b1;
                idx_o = IW'(c);
                best  = val_i[c];
            end
        end
    end
endmodule

// File: rtl/arrival_rank.sv
// Computes the urgency of each arriving cell and whether its queue has room.
module arrival_rank #(
    parameter  int N      = 4,
    parameter  int UW     = 8,
    parameter  int QDEPTH = 16,
    localparam int PW     = $clog2(N),
    localparam int CW     = $clog2(QDEPTH + 1),
    localparam int TW     = $clog2(N * QDEPTH + 1)
) (
    input  logic [N-1:0][N-1:0][CW-1:0] occ_i,
    input  logic [N-1:0]                vld_i,
    input  logic [N-1:0][PW-1:0]        dst_i,
    output logic [N-1:0]                acc_o,
    output logic [N-1:0][UW-1:0]        urg_o
);
    localparam int UMAX = (1 << UW) - 1;

    logic [N-1:0][TW-1:0] tot;
    int                   cnt;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            tot[j] = '0;
            for (int i = 0; i < N; i++) tot[j] = tot[j] + TW'(occ_i[i][j]);
        end
    end

    always_comb begin
        acc_o = '0;
        urg_o = '0;
        cnt   = 0;
        for (int i = 0; i < N; i++) begin
            acc_o[i] = vld_i[i] && (occ_i[i][dst_i[i]] < CW'(QDEPTH));
            cnt      = int'(tot[dst_i[i]]);
            for (int k = 0; k < i; k++) begin
                if (acc_o[k] && (dst_i[k] == dst_i[i])) cnt = cnt + 1;
            end
            urg_o[i] = (cnt > UMAX) ? UW'(UMAX) : UW'(cnt);
        end
    end
endmodule

// File: rtl/urgency_sched.sv
module urgency_sched
    import urg_sched_pkg::*;
#(
    parameter  int N      = 4,
    parameter  int UW     = 8,
    parameter  int QDEPTH = 16,
    parameter  int TIE_RR = 0,
    localparam int PW     = $clog2(N),
    localparam int CW     = $clog2(QDEPTH + 1),
    localparam int TW     = $clog2(N * QDEPTH + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [N-1:0]          arv_vld_i,
    input  logic [N-1:0][PW-1:0]  arv_dst_i,
    input  logic                  phase_start_i,
    output logic                  busy_o,
    output logic                  match_vld_o,
    output logic [N-1:0]          match_hit_o,
    output logic [N-1:0][PW-1:0]  match_dst_o,
    output logic [N-1:0]          xfer_o
);
    localparam int UMAX = (1 << UW) - 1;

    typedef struct packed {
        sched_st_e                     st;
        logic [PW-1:0]                 round;
        logic [N-1:0]                  in_m;
        logic [N-1:0]                  out_m;
        logic [N-1:0][PW-1:0]          dst;
        logic [N-1:0][N-1:0][CW-1:0]   occ;
        logic [N-1:0][N-1:0][UW-1:0]   urg;
        logic [N-1:0][PW-1:0]          ptr;
        logic                          mvld;
    } sched_t;

    sched_t st_d, st_q;

    logic [N-1:0][N-1:0][CW-1:0] occ_q;
    logic [N-1:0][N-1:0][TW-1:0] oth;
    logic [N-1:0]                arv_acc;
    logic [N-1:0][UW-1:0]        arv_urg;
    logic [N-1:0][N-1:0]         rq_vld;
    logic [N-1:0][N-1:0][UW-1:0] rq_val;
    logic [N-1:0]                rq_hit;
    logic [N-1:0][PW-1:0]        rq_idx;
    logic [N-1:0]                rq_on;
    logic [N-1:0][N-1:0]         gt_vld;
    logic [N-1:0]                gt_hit;
    logic [N-1:0][PW-1:0]        gt_idx;

    function automatic logic [UW-1:0] sat_u(input int x);
        return (x > UMAX) ? UW'(UMAX) : UW'(x);
    endfunction

    arrival_rank #(.N(N), .UW(UW), .QDEPTH(QDEPTH)) u_rank (
        .occ_i (st_q.occ),
        .vld_i (arv_vld_i),
        .dst_i (arv_dst_i),
        .acc_o (arv_acc),
        .urg_o (arv_urg)
    );

    // cells for output j held at inputs other than i
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                oth[i][j] = '0;
                for (int k = 0; k < N; k++) begin
                    if (k != i) oth[i][j] = oth[i][j] + TW'(st_q.occ[k][j]);
                end
            end
        end
    end

    // request candidates, one column per output
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                rq_vld[j][i] = !st_q.in_m[i] && (st_q.occ[i][j] != '0);
                rq_val[j][i] = st_q.urg[i][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_req
        min_pick #(.N(N), .W(UW)) u_pick (
            .vld_i   (rq_vld[j]),
            .val_i   (rq_val[j]),
            .start_i ('0),
            .hit_o   (rq_hit[j]),
            .idx_o   (rq_idx[j])
        );
    end

    always_comb begin
        for (int j = 0; j < N; j++) begin
            rq_on[j] = rq_hit[j] && !st_q.out_m[j] && (st_q.st == ST_RUN);
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                gt_vld[i][j] = rq_on[j] && (rq_idx[j] == PW'(i));
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_gnt
        logic [PW-1:0] start;
        if (TIE_RR != 0) begin : g_rot
            assign start = st_q.ptr[i];
        end else begin : g_low
            assign start = '0;
        end
        min_pick #(.N(N), .W(UW)) u_pick (
            .vld_i   (gt_vld[i]),
            .val_i   (st_q.urg[i]),
            .start_i (start),
            .hit_o   (gt_hit[i]),
            .idx_o   (gt_idx[i])
        );
    end

    always_comb begin
        logic [PW-1:0] d;
        d         = '0;
        st_d      = st_q;
        st_d.mvld = 1'b0;

        if (st_q.st == ST_IDLE) begin
            if (phase_start_i) begin
                st_d.st    = ST_RUN;
                st_d.round = '0;
                st_d.in_m  = '0;
                st_d.out_m = '0;
                st_d.dst   = '0;
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        if ((st_q.occ[i][j] != '0) && (st_q.urg[i][j] != '0))
                            st_d.urg[i][j] = st_q.urg[i][j] - 1'b1;
                    end
                end
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gt_hit[i]) begin
                    st_d.in_m[i]          = 1'b1;
                    st_d.dst[i]           = gt_idx[i];
                    st_d.out_m[gt_idx[i]] = 1'b1;
                end
            end
            st_d.round = st_q.round + 1'b1;
            if (!(|gt_hit) || (st_q.round == PW'(N - 1))) begin
                st_d.st   = ST_IDLE;
                st_d.mvld = 1'b1;
                for (int i = 0; i < N; i++) begin
                    if (st_d.in_m[i]) begin
                        d                = st_d.dst[i];
                        st_d.occ[i][d]   = st_q.occ[i][d] - 1'b1;
                        if (st_q.occ[i][d] > CW'(1))
                            st_d.urg[i][d] = sat_u(int'(oth[i][d]));
                        st_d.ptr[i]      = (d == PW'(N - 1)) ? '0 : d + 1'b1;
                    end
                end
            end
        end

        for (int i = 0; i < N; i++) begin
            if (arv_acc[i]) begin
                d = arv_dst_i[i];
                if (st_d.occ[i][d] == '0) st_d.urg[i][d] = arv_urg[i];
                st_d.occ[i][d] = st_d.occ[i][d] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign occ_q       = st_q.occ;
    assign busy_o      = (st_q.st == ST_RUN);
    assign match_vld_o = st_q.mvld;
    assign match_hit_o = st_q.in_m;
    assign match_dst_o = st_q.dst;
    assign xfer_o      = st_q.in_m & {N{st_q.mvld}};
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter  int N      = 4,
    parameter  int QDEPTH = 16,
    localparam int PW     = $clog2(N),
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        phase_start_i,
    input logic                        busy_o,
    input logic                        match_vld_o,
    input logic [N-1:0]                match_hit_o,
    input logic [N-1:0][PW-1:0]        match_dst_o,
    input logic [N-1:0][N-1:0][CW-1:0] occ_i
);
    logic dup;
    logic over;

    always_comb begin
        dup  = 1'b0;
        over = 1'b0;
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                if (match_hit_o[a] && match_hit_o[b] && (match_dst_o[a] == match_dst_o[b]))
                    dup = 1'b1;
            end
            for (int j = 0; j < N; j++) begin
                if (occ_i[a][j] > CW'(QDEPTH)) over = 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i) !over); // R3
    AST_OUT_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i) match_vld_o |-> !dup); // R6
    AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (rst_i) match_vld_o |=> !match_vld_o); // R8
    AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i) $fell(busy_o) |-> match_vld_o); // R8
    AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i) (phase_start_i && !busy_o) |=> busy_o); // R8
endmodule

bind urgency_sched sched_chk #(.N(N), .QDEPTH(QDEPTH)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .phase_start_i (phase_start_i),
    .busy_o        (busy_o),
    .match_vld_o   (match_vld_o),
    .match_hit_o   (match_hit_o),
    .match_dst_o   (match_dst_o),
    .occ_i         (occ_q)
);

// File: tb/urgency_sched_tb.sv
`timescale 1ns/1ps
module urgency_sched_tb;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int QD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]         arv_vld = '0;
    logic [N-1:0][PW-1:0] arv_dst = '0;
    logic                 ps = 1'b0;

    logic                 busy0, busy1, mv0, mv1;
    logic [N-1:0]         hit0, hit1, xf0, xf1;
    logic [N-1:0][PW-1:0] dst0, dst1;

    int checks = 0;
    int fails  = 0;

    int m_occ [2][N][N];
    int m_urg [2][N][N];
    int m_ptr [2][N];
    int e_hit [2][N];
    int e_dst [2][N];

    always #2.5 clk = ~clk;

    urgency_sched #(.N(N), .UW(8), .QDEPTH(QD), .TIE_RR(0)) u_dut (
        .clk_i(clk), .rst_i(rst), .arv_vld_i(arv_vld), .arv_dst_i(arv_dst),
        .phase_start_i(ps), .busy_o(busy0), .match_vld_o(mv0),
        .match_hit_o(hit0), .match_dst_o(dst0), .xfer_o(xf0));

    urgency_sched #(.N(N), .UW(8), .QDEPTH(QD), .TIE_RR(1)) u_dut_rr (
        .clk_i(clk), .rst_i(rst), .arv_vld_i(arv_vld), .arv_dst_i(arv_dst),
        .phase_start_i(ps), .busy_o(busy1), .match_vld_o(mv1),
        .match_hit_o(hit1), .match_dst_o(dst1), .xfer_o(xf1));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 R3: arrival bookkeeping
    function automatic void model_arrive(int v, logic [N-1:0] vld, logic [N-1:0][PW-1:0] dst);
        int tot [N];
        int add [N];
        int j, u;
        for (int k = 0; k < N; k++) begin
            tot[k] = 0;
            add[k] = 0;
            for (int i = 0; i < N; i++) tot[k] += m_occ[v][i][k];
        end
        for (int i = 0; i < N; i++) begin
            if (vld[i]) begin
                j = int'(dst[i]);
                if (m_occ[v][i][j] < QD) begin
                    u = tot[j] + add[j];
                    if (u > 255) u = 255;
                    if (m_occ[v][i][j] == 0) m_urg[v][i][j] = u;
                    m_occ[v][i][j]++;
                    add[j]++;
                end
            end
        end
    endfunction

    // R4..R9: one phase
    function automatic void model_phase(int v);
        int inm [N]; int outm [N]; int dm [N]; int rv [N]; int ri [N];
        int bu, bj, c, st, oth, j;
        bit newg;
        for (int i = 0; i < N; i++) begin
            inm[i] = 0; outm[i] = 0; dm[i] = 0;
            for (int k = 0; k < N; k++)
                if (m_occ[v][i][k] > 0 && m_urg[v][i][k] > 0) m_urg[v][i][k]--;
        end
        for (int r = 0; r < N; r++) begin
            for (int o = 0; o < N; o++) begin
                rv[o] = 0; ri[o] = 0; bu = 0;
                if (!outm[o]) begin
                    for (int i = 0; i < N; i++) begin
                        if (!inm[i] && m_occ[v][i][o] > 0 && (!rv[o] || m_urg[v][i][o] < bu)) begin
                            rv[o] = 1; ri[o] = i; bu = m_urg[v][i][o];
                        end
                    end
                end
            end
            newg = 0;
            for (int i = 0; i < N; i++) begin
                if (!inm[i]) begin
                    st = (v == 1) ? m_ptr[v][i] : 0;
                    bj = -1; bu = 0;
                    for (int k = 0; k < N; k++) begin
                        c = (st + k) % N;
                        if (rv[c] && ri[c] == i && (bj < 0 || m_urg[v][i][c] < bu)) begin
                            bj = c; bu = m_urg[v][i][c];
                        end
                    end
                    if (bj >= 0) begin
                        inm[i] = 1; dm[i] = bj; outm[bj] = 1; newg = 1;
                    end
                end
            end
            if (!newg) break;
        end
        for (int i = 0; i < N; i++) begin
            e_hit[v][i] = inm[i];
            e_dst[v][i] = inm[i] ? dm[i] : 0;
            if (inm[i]) begin
                j = dm[i];
                oth = 0;
                for (int k = 0; k < N; k++) if (k != i) oth += m_occ[v][k][j];
                m_occ[v][i][j]--;
                if (m_occ[v][i][j] > 0) m_urg[v][i][j] = (oth > 255) ? 255 : oth;
                m_ptr[v][i] = (j + 1) % N;
            end
        end
    endfunction

    task automatic do_arrive(input logic [N-1:0] vld, input logic [N-1:0][PW-1:0] dst);
        @(negedge clk);
        arv_vld = vld;
        arv_dst = dst;
        model_arrive(0, vld, dst);
        model_arrive(1, vld, dst);
        @(negedge clk);
        arv_vld = '0;
    endtask

    task automatic do_phase(input bit extra, input string tag);
        int n0, n1, eh, ed;
        logic [N-1:0]         h0, h1, x0, x1;
        logic [N-1:0][PW-1:0] d0, d1;
        n0 = 99; n1 = 99;
        h0 = '0; h1 = '0; x0 = '0; x1 = '0; d0 = '0; d1 = '0;
        @(negedge clk);
        ps = 1'b1;
        model_phase(0);
        model_phase(1);
        @(negedge clk);
        ps = extra;  // R10: start while busy
        chk({tag, " R8 busy after start"}, int'({busy1, busy0}), 3);
        for (int n = 1; n <= N + 1; n++) begin
            @(negedge clk);
            ps = 1'b0;
            if (mv0 && n0 == 99) begin n0 = n; h0 = hit0; d0 = dst0; x0 = xf0; end
            if (mv1 && n1 == 99) begin n1 = n; h1 = hit1; d1 = dst1; x1 = xf1; end
        end
        chk({tag, " R8 latency dut0 within N"}, int'(n0 <= N), 1);
        chk({tag, " R8 latency dut1 within N"}, int'(n1 <= N), 1);
        chk({tag, " R10 idle after pulse"}, int'({busy1, busy0, mv1, mv0}), 0);
        eh = 0; ed = 0;
        for (int i = 0; i < N; i++) begin
            eh |= e_hit[0][i] << i;
            ed |= (e_dst[0][i] << (PW * i));
            if (!h0[i]) d0[i] = '0;
        end
        chk({tag, " R6 hit dut0"}, int'(h0), eh);
        chk({tag, " R6 dst dut0"}, int'(d0), ed);
        chk({tag, " R9 xfer dut0"}, int'(x0), eh);
        eh = 0; ed = 0;
        for (int i = 0; i < N; i++) begin
            eh |= e_hit[1][i] << i;
            ed |= (e_dst[1][i] << (PW * i));
            if (!h1[i]) d1[i] = '0;
        end
        chk({tag, " R7 hit dut1"}, int'(h1), eh);
        chk({tag, " R7 dst dut1"}, int'(d1), ed);
    endtask

    function automatic logic [N-1:0][PW-1:0] dv(int a, int b, int c, int d);
        logic [N-1:0][PW-1:0] r;
        r[0] = PW'(a); r[1] = PW'(b); r[2] = PW'(c); r[3] = PW'(d);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < N; i++) begin
                m_ptr[v][i] = 0;
                for (int j = 0; j < N; j++) begin m_occ[v][i][j] = 0; m_urg[v][i][j] = 0; end
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", int'({busy1, busy0}), 0);
        chk("R1 match_vld after reset", int'({mv1, mv0}), 0);
        chk("R1 hit after reset", int'({hit1, hit0}), 0);
        do_phase(1'b0, "R1 empty");

        // R2 same-cycle arrivals to one output rank by input number
        do_arrive(4'b0011, dv(0, 0, 0, 0));
        do_arrive(4'b0100, dv(0, 0, 1, 0));
        do_arrive(4'b1000, dv(0, 0, 0, 0));
        do_phase(1'b0, "R2 R5");
        do_phase(1'b1, "R9 reload");
        do_phase(1'b0, "R9 drain");

        // R6 R7 tie at one input: equal urgencies for two outputs
        do_arrive(4'b0001, dv(0, 0, 0, 0));
        do_arrive(4'b0001, dv(1, 0, 0, 0));
        do_arrive(4'b0001, dv(0, 0, 0, 0));
        do_arrive(4'b0001, dv(1, 0, 0, 0));
        do_phase(1'b0, "R6 tie first");
        do_phase(1'b0, "R7 tie second");
        do_phase(1'b0, "R7 tie third");
        do_phase(1'b0, "R4 drain");

        // R3 seventeen cells into one queue, plus a competitor
        for (int k = 0; k < QD + 1; k++) do_arrive(4'b1000, dv(0, 0, 0, 3));
        do_arrive(4'b0100, dv(0, 0, 3, 0));
        for (int k = 0; k < QD + 2; k++) do_phase(k[0], "R3 drain");

        // R4 R5 random contention
        for (int it = 0; it < 300; it++) begin
            int nc;
            nc = 1 + int'($urandom_range(2));
            for (int c = 0; c < nc; c++)
                do_arrive(N'($urandom), dv($urandom_range(3), $urandom_range(3),
                                           $urandom_range(3), $urandom_range(3)));
            do_phase(1'($urandom_range(1)), "R4 R5 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule